// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

A purely combinational 32-bit arithmetic and logic unit meant for the execute stage of a simple datapath. Two operands, a shift amount and a handful of small select fields go in. A result comes out together with three flags: zero, sign and signed overflow. There is no clock, no reset and no state. Every output settles from the current inputs alone.

Inside, four units work side by side:
- a barrel shifter that acts on operand B;
- an adder/subtractor, which negates B by inverting it and forcing the carry-in to one;
- a logic unit with four functions;
- a signed less-than path.

A two-level select picks one unit's output. The top-level field chooses the unit, and each unit's own field chooses its function. The less-than result does not use a separate comparator. It reuses the subtractor: the sign of the difference is corrected by the overflow flag.

Top module: `alu_shift_top`

## Requirements
- R1: `resSel` picks the result source: 2'b00 logic unit, 2'b01 adder/subtractor, 2'b10 set-less-than, 2'b11 shifter.
- R2: With `resSel`=2'b01, the result is `opA + opB` modulo 2^32 when `arithSub`=0 and `opA - opB` modulo 2^32 when `arithSub`=1.
- R3: `overflow` is high exactly when the adder's operation overflows as a two's-complement signed operation. The adder subtracts when `arithSub`=1 or `resSel`=2'b10, and adds otherwise. Adding two operands of opposite sign never overflows.
- R4: `sign` equals bit 31 of the adder/subtractor output, whichever source is selected.
- R5: With `resSel`=2'b00, `logicOp` picks the function: 2'b00 AND, 2'b01 OR, 2'b10 NOR, 2'b11 XOR.
- R6: With `resSel`=2'b10, result bit 0 is 1 exactly when `opA` < `opB` as signed numbers. This holds for mixed signs and for differences that overflow. Bits 31..1 are 0.
- R7: With `resSel`=2'b11, `shiftOp` acts on `opB` by `shAmt` places:
  - 2'b00 passes `opB` through unchanged;
  - 2'b01 shifts left and fills with zeros;
  - 2'b10 shifts right and fills with zeros;
  - 2'b11 shifts right and fills with `opB[31]`.
- R8: A shift amount of 0 returns `opB` unchanged in every shift mode. An amount of 31 moves a single surviving bit (or sign fill) to the far end.
- R9: `zero` is high exactly when all 32 result bits are 0, for every source.
- R10: Fields of units that are not selected have no effect on the result. `arithSub` has no effect when the less-than path is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, also the value that is shifted |
| shAmt | input | 5 | Shift distance |
| resSel | input | 2 | Result source select |
| shiftOp | input | 2 | Shift mode |
| arithSub | input | 1 | 0 add, 1 subtract |
| logicOp | input | 2 | Logic function |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zeros |
| sign | output | 1 | Bit 31 of the adder output |
| overflow | output | 1 | Signed overflow of the adder operation |

## Verification
The assertions watch relations that must hold for any operand values:
- less-than results have zero upper bits and follow operand A's sign when the signs differ;
- adding operands of opposite sign never raises overflow;
- a pass-through or zero-distance shift returns B;
- an XOR of equal operands raises zero;
- adding zero returns A with A's sign.

Only the directed scenarios, compared against an independent reference model, can show the actual arithmetic values, the overflow corners at the extremes of the signed range, the exact fill of each shift mode at every distance, and that unselected fields change nothing.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  // Result source encoding (behavioural: decoded by the control module)
  localparam logic [1:0] RES_LOGIC = 2'b00;
  localparam logic [1:0] RES_ARITH = 2'b01;
  localparam logic [1:0] RES_SLT   = 2'b10;
  localparam logic [1:0] RES_SHIFT = 2'b11;

  // Shift modes
  localparam logic [1:0] SH_NONE  = 2'b00;
  localparam logic [1:0] SH_LEFT  = 2'b01;
  localparam logic [1:0] SH_RIGHT = 2'b10;
  localparam logic [1:0] SH_ARITH = 2'b11;

  // Logic functions
  localparam logic [1:0] LG_AND = 2'b00;
  localparam logic [1:0] LG_OR  = 2'b01;
  localparam logic [1:0] LG_NOR = 2'b10;
  localparam logic [1:0] LG_XOR = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic       selLogic;
    logic       selArith;
    logic       selSlt;
    logic       selShift;
    logic       invertB;
    logic       carryIn;
    logic       shiftEn;
    logic       shiftLeft;
    logic       fillSign;
    logic [1:0] logicFn;
  } aluStrobes_t;

endpackage

// File: rtl/alu_shift_ctrl.sv
module alu_shift_ctrl
  import alu_shift_pkg::*;
(
  input  logic [1:0]  resSel,
  input  logic [1:0]  shiftOp,
  input  logic        arithSub,
  input  logic [1:0]  logicOp,
  output aluStrobes_t strobes
);

  logic subtractMode;

  // Less-than always runs the subtractor, regardless of arithSub (R6, R10)
  assign subtractMode = arithSub | (resSel == RES_SLT);

  always_comb begin
    strobes          = '0;
    strobes.selLogic = (resSel == RES_LOGIC);
    strobes.selArith = (resSel == RES_ARITH);
    strobes.selSlt   = (resSel == RES_SLT);
    strobes.selShift = (resSel == RES_SHIFT);
    strobes.invertB  = subtractMode;
    strobes.carryIn  = subtractMode;
    strobes.logicFn  = logicOp;
    unique case (shiftOp)
      SH_NONE: begin
        strobes.shiftEn   = 1'b0;
        strobes.shiftLeft = 1'b0;
        strobes.fillSign  = 1'b0;
      end
      SH_LEFT: begin
        strobes.shiftEn   = 1'b1;
        strobes.shiftLeft = 1'b1;
        strobes.fillSign  = 1'b0;
      end
      SH_RIGHT: begin
        strobes.shiftEn   = 1'b1;
        strobes.shiftLeft = 1'b0;
        strobes.fillSign  = 1'b0;
      end
      default: begin
        strobes.shiftEn   = 1'b1;
        strobes.shiftLeft = 1'b0;
        strobes.fillSign  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_barrel_shifter.sv
module alu_barrel_shifter #(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SHW-1:0]   amount,
  input  logic             shiftEn,
  input  logic             shiftLeft,
  input  logic             fillSign,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] revOut;
  logic [WIDTH-1:0] stage [0:SHW];
  logic             fillBit;

  assign fillBit = fillSign & dataIn[WIDTH-1];

  // A left shift is a right shift of the bit-reversed operand
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign revIn[i]  = dataIn[WIDTH-1-i];
    assign revOut[i] = stage[SHW][WIDTH-1-i];
  end

  assign stage[0] = shiftLeft ? revIn : dataIn;

  // log2(WIDTH) stages, stage s moves by 2**s places
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s]
                      ? {{STEP{fillBit}}, stage[s][WIDTH-1:STEP]}
                      : stage[s];
  end

  assign dataOut = !shiftEn  ? dataIn :
                   shiftLeft ? revOut : stage[SHW];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invertB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);

  logic [WIDTH-1:0] bOp;

  assign bOp      = b ^ {WIDTH{invertB}};
  assign sum      = a + bOp + {{(WIDTH-1){1'b0}}, carryIn};
  assign overflow = (a[WIDTH-1] == bOp[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

endmodule

// File: rtl/alu_shift_datapath.sv
module alu_shift_datapath
  import alu_shift_pkg::*;
#(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             sign,
  output logic             overflow
);

  logic [WIDTH-1:0] shiftOut;
  logic [WIDTH-1:0] sumOut;
  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] sltOut;
  logic             addOvf;

  alu_barrel_shifter #(.WIDTH(WIDTH)) u_shifter (
    .dataIn    (opB),
    .amount    (shAmt),
    .shiftEn   (strobes.shiftEn),
    .shiftLeft (strobes.shiftLeft),
    .fillSign  (strobes.fillSign),
    .dataOut   (shiftOut)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a        (opA),
    .b        (opB),
    .invertB  (strobes.invertB),
    .carryIn  (strobes.carryIn),
    .sum      (sumOut),
    .overflow (addOvf)
  );

  always_comb begin
    unique case (strobes.logicFn)
      LG_AND:  logicOut = opA & opB;
      LG_OR:   logicOut = opA | opB;
      LG_NOR:  logicOut = ~(opA | opB);
      default: logicOut = opA ^ opB;
    endcase
  end

  // True sign of the difference = sum sign corrected by overflow
  assign sltOut = {{(WIDTH-1){1'b0}}, sumOut[WIDTH-1] ^ addOvf};

  // One-hot AND-OR select
  assign result = ({WIDTH{strobes.selLogic}} & logicOut)
                | ({WIDTH{strobes.selArith}} & sumOut)
                | ({WIDTH{strobes.selSlt}}   & sltOut)
                | ({WIDTH{strobes.selShift}} & shiftOut);

  assign zero     = ~|result;
  assign sign     = sumOut[WIDTH-1];
  assign overflow = addOvf;

endmodule

// File: rtl/alu_shift_top.sv
module alu_shift_top
  import alu_shift_pkg::*;
#(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  logic [1:0]       resSel,
  input  logic [1:0]       shiftOp,
  input  logic             arithSub,
  input  logic [1:0]       logicOp,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             sign,
  output logic             overflow
);

  aluStrobes_t strobes;

  alu_shift_ctrl u_ctrl (
    .resSel   (resSel),
    .shiftOp  (shiftOp),
    .arithSub (arithSub),
    .logicOp  (logicOp),
    .strobes  (strobes)
  );

  alu_shift_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero),
    .sign     (sign),
    .overflow (overflow)
  );

endmodule

// File: rtl/alu_shift_checker.sv
module alu_shift_checker #(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SHW-1:0]   shAmt,
  input logic [1:0]       resSel,
  input logic [1:0]       shiftOp,
  input logic             arithSub,
  input logic [1:0]       logicOp,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             sign,
  input logic             overflow
);

  // Combinational block: immediate checks on settled port values
  always_comb begin
    if (resSel == 2'b10) begin
      assert_slt_upper_R6: assert (result[WIDTH-1:1] == '0)
        else $error("less-than upper bits not zero");
    end
    if (resSel == 2'b10 && opA[WIDTH-1] != opB[WIDTH-1]) begin
      assert_slt_mixed_R6: assert (result[0] == opA[WIDTH-1])
        else $error("mixed-sign less-than wrong");
    end
    if (resSel == 2'b01 && !arithSub && opA[WIDTH-1] != opB[WIDTH-1]) begin
      assert_no_overflow_R3: assert (!overflow)
        else $error("overflow on opposite-sign add");
    end
    if (resSel == 2'b11 && (shiftOp == 2'b00 || shAmt == '0)) begin
      assert_shift_pass_R8: assert (result == opB)
        else $error("zero-distance shift altered operand");
    end
    if (resSel == 2'b00 && logicOp == 2'b11 && opA == opB) begin
      assert_xor_zero_R9: assert (zero)
        else $error("zero flag low for equal-operand xor");
    end
    if (resSel == 2'b01 && !arithSub && opB == '0) begin
      assert_add_identity_R2: assert (result == opA && sign == opA[WIDTH-1])
        else $error("adding zero changed operand");
    end
  end

endmodule

bind alu_shift_top alu_shift_checker #(.WIDTH(WIDTH)) u_checker (
  .opA      (opA),
  .opB      (opB),
  .shAmt    (shAmt),
  .resSel   (resSel),
  .shiftOp  (shiftOp),
  .arithSub (arithSub),
  .logicOp  (logicOp),
  .result   (result),
  .zero     (zero),
  .sign     (sign),
  .overflow (overflow)
);

// File: tb/alu_shift_top_tb.sv
module alu_shift_top_tb;

  logic        clk = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  shAmt = '0;
  logic [1:0]  resSel = '0, shiftOp = '0, logicOp = '0;
  logic        arithSub = 1'b0;
  logic [31:0] result;
  logic        zero, sign, overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  alu_shift_top u_dut (
    .opA(opA), .opB(opB), .shAmt(shAmt), .resSel(resSel), .shiftOp(shiftOp),
    .arithSub(arithSub), .logicOp(logicOp),
    .result(result), .zero(zero), .sign(sign), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Independent reference model
  task automatic model(input logic [31:0] a, b, input logic [4:0] amt,
                       input logic [1:0] rs, sh, lg, input logic sub,
                       output logic [31:0] r, output logic z, s, o);
    logic signed [63:0] wide;
    logic [31:0] arith;
    bit useSub;
    useSub = sub || (rs == 2'b10);
    wide   = useSub ? ($signed({{32{a[31]}}, a}) - $signed({{32{b[31]}}, b}))
                    : ($signed({{32{a[31]}}, a}) + $signed({{32{b[31]}}, b}));
    arith  = useSub ? a - b : a + b;
    o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    s = arith[31];
    case (rs)
      2'b00: case (lg)
               2'b00: r = a & b;
               2'b01: r = a | b;
               2'b10: r = ~(a | b);
               default: r = a ^ b;
             endcase
      2'b01: r = arith;
      2'b10: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: case (sh)
               2'b00: r = b;
               2'b01: r = b << amt;
               2'b10: r = b >> amt;
               default: r = $unsigned($signed(b) >>> amt);
             endcase
    endcase
    z = (r == 32'd0);
  endtask

  task automatic apply(input logic [31:0] a, b, input logic [4:0] amt,
                       input logic [1:0] rs, sh, lg, input logic sub,
                       input string tag);
    logic [31:0] er;
    logic ez, es, eo;
    @(posedge clk);
    opA = a; opB = b; shAmt = amt; resSel = rs; shiftOp = sh;
    logicOp = lg; arithSub = sub;
    @(negedge clk);
    model(a, b, amt, rs, sh, lg, sub, er, ez, es, eo);
    checks++;
    if (result !== er || zero !== ez || sign !== es || overflow !== eo) begin
      errors++;
      $display("FAIL %s: actual r=%h z=%b s=%b o=%b expected r=%h z=%b s=%b o=%b",
               tag, result, zero, sign, overflow, er, ez, es, eo);
    end
  endtask

  task automatic test_idle();
    // all-zero inputs: logic AND of zeros
    apply(0, 0, 0, 2'b00, 2'b00, 2'b00, 0, "R9 idle zero");
  endtask

  task automatic test_logic();
    for (int f = 0; f < 4; f++) begin
      apply(32'hF0F0_1234, 32'h0FF0_AAAA, 0, 2'b00, 0, f[1:0], 0, "R5 logic fn");
      apply(32'hFFFF_FFFF, 32'h0000_0000, 0, 2'b00, 0, f[1:0], 0, "R5 logic extremes");
    end
    apply(32'h5A5A_5A5A, 32'h5A5A_5A5A, 0, 2'b00, 0, 2'b11, 0, "R9 xor equal zero");
    apply(32'hFFFF_0000, 32'h0000_FFFF, 0, 2'b00, 0, 2'b10, 0, "R9 nor to zero");
  endtask

  task automatic test_arith();
    apply(32'd100, 32'd23, 0, 2'b01, 0, 0, 0, "R2 add");
    apply(32'd100, 32'd23, 0, 2'b01, 0, 0, 1, "R2 sub");
    apply(32'd5, 32'd9, 0, 2'b01, 0, 0, 1, "R4 sub negative sign");
    apply(32'hFFFF_FFFF, 32'd1, 0, 2'b01, 0, 0, 0, "R2 wrap to zero");
    apply(32'd77, 32'd77, 0, 2'b01, 0, 0, 1, "R9 sub equal zero");
  endtask

  task automatic test_overflow();
    apply(32'h7FFF_FFFF, 32'd1, 0, 2'b01, 0, 0, 0, "R3 pos+pos overflow");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 0, 2'b01, 0, 0, 0, "R3 neg+neg overflow");
    apply(32'h8000_0000, 32'd1, 0, 2'b01, 0, 0, 1, "R3 min-1 overflow");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 2'b01, 0, 0, 1, "R3 max-(-1) overflow");
    apply(32'h0000_0000, 32'h8000_0000, 0, 2'b01, 0, 0, 1, "R3 0-min overflow");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 0, 2'b01, 0, 0, 0, "R3 mixed add no overflow");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'b01, 0, 0, 1, "R3 equal sub no overflow");
  endtask

  task automatic test_slt();
    apply(32'd3, 32'd7, 0, 2'b10, 0, 0, 0, "R6 small less");
    apply(32'd7, 32'd3, 0, 2'b10, 0, 0, 0, "R6 small greater");
    apply(32'hFFFF_FFFF, 32'd1, 0, 2'b10, 0, 0, 0, "R6 neg vs pos");
    apply(32'd1, 32'hFFFF_FFFF, 0, 2'b10, 0, 0, 0, "R6 pos vs neg");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 0, 2'b10, 0, 0, 0, "R6 min vs max overflow");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 0, 2'b10, 0, 0, 0, "R6 max vs min overflow");
    apply(32'd42, 32'd42, 0, 2'b10, 0, 0, 0, "R6 equal");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 0, 2'b10, 0, 0, 1, "R10 slt ignores arithSub");
  endtask

  task automatic test_shift();
    for (int m = 0; m < 4; m++) begin
      apply(0, 32'h8421_F00D, 5'd0, 2'b11, m[1:0], 0, 0, "R8 amount zero");
      apply(0, 32'h8421_F00D, 5'd7, 2'b11, m[1:0], 0, 0, "R7 mode amount 7");
      apply(0, 32'h8000_0001, 5'd31, 2'b11, m[1:0], 0, 0, "R8 amount 31");
      apply(0, 32'h7000_0001, 5'd16, 2'b11, m[1:0], 0, 0, "R7 positive operand");
    end
    for (int k = 0; k < 32; k++)
      apply(0, 32'hC000_0003, k[4:0], 2'b11, 2'b11, 0, 0, "R7 arith fill sweep");
    apply(0, 32'h0000_0001, 5'd31, 2'b11, 2'b10, 0, 0, "R9 shift out to zero");
  endtask

  task automatic test_select_and_ignore();
    for (int rs = 0; rs < 4; rs++)
      apply(32'h1234_5678, 32'h0000_0F03, 5'd4, rs[1:0], 2'b01, 2'b01, 0, "R1 select sweep");
    for (int v = 0; v < 4; v++) begin
      apply(32'd1000, 32'd24, v[4:0] + 5'd3, 2'b01, v[1:0], v[1:0], 0, "R10 arith ignores others");
      apply(32'hAAAA_0000, 32'h00FF_00FF, v[4:0], 2'b00, v[1:0], 2'b01, v[0], "R10 logic ignores others");
      apply(32'h1111_1111, 32'hF000_0000, 5'd4, 2'b11, 2'b11, v[1:0], v[0], "R10 shift ignores others");
    end
  endtask

  initial begin
    test_idle();
    test_logic();
    test_arith();
    test_overflow();
    test_slt();
    test_shift();
    test_select_and_ignore();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule